// File: doc/BRIEF.md
# Processor Interrupt Recognition Controller

This block decides which of eight external interrupt sources a processor core takes, and in which cycle. Each source reaches the block on its own pin. Some pins are captured on a rising edge and stay pending. Others count only while they are held. One is captured only on bus-ready strobes. After the block has normalized every source to active-high, it applies the interrupt-enable mask and the NMI block, then picks a single winner by fixed priority. It does this only when the core signals an instruction-retirement boundary.

On recognition the block issues a one-cycle one-hot code and a pipeline-flush pulse in the same cycle. Four sources save state to the stack. For these, the pulse is held back until the write buffer reports empty. After a recognition the block stays busy until the core reports that the handler has started or the hardware action has completed. Edge sources that are still pending are then taken at a later boundary.

Top module: `intr_recog`

## Requirements
- R1: After a synchronous reset, `recog_code` is zero, `flush_pulse` is low and `busy` is low.
- R2: A selection is made only in a cycle where `retire_bnd` is high and the block is not busy. The recognition shows as `recog_code` for exactly one cycle, with `flush_pulse` high in that same cycle.
- R3: The edge sources are latched on a rising edge of the normalized pin and stay pending after the pin drops. They are flush (bit 2), system-management (bit 3), init (bit 4) and NMI (bit 5). A recognition clears its latch. If a new rising edge arrives in the recognition cycle, the latch is set again.
- R4: The held sources count only while the pin is asserted at the boundary. They are run/stop (bit 1, pin active low), INTR (bit 6) and stop-clock (bit 7).
- R5: Bus-check (bit 0) is sampled into a latch in every cycle in which `bus_rdy` is high. It is not seen without a strobe, and it stays pending until it is recognized.
- R6: When several sources are eligible, the lowest bit index wins. The order is bus-check, run/stop, flush, system-management, init, NMI, INTR, stop-clock.
- R7: INTR is not eligible while `ie_flag` is low.
- R8: After an NMI is recognized, a new NMI stays pending and is not recognized until `nmi_iret` is pulsed.
- R9: Bus-check, system-management, NMI and INTR write to the stack, so their pulse waits until `wbe` is high, with `busy` high during the wait. Run/stop, flush, init and stop-clock are recognized regardless of `wbe`.
- R10: `busy` stays high from selection until `svc_done`, and no boundary is honoured while it is high. Latched sources that were not chosen are recognized at a later boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pin | input | 8 | Raw interrupt pins, bit order as in R6; bit 1 active low |
| bus_rdy | input | 1 | Bus-ready strobe that samples bus-check |
| retire_bnd | input | 1 | Instruction-retirement boundary |
| ie_flag | input | 1 | Interrupt-enable flag for INTR |
| wbe | input | 1 | Write buffer empty |
| nmi_iret | input | 1 | NMI handler return |
| svc_done | input | 1 | Handler started or hardware action completed |
| recog_code | output | 8 | One-hot recognized source, one-cycle pulse |
| flush_pulse | output | 1 | Pipeline flush, one cycle |
| busy | output | 1 | Recognition in progress |

## Verification
The bench builds the block with its default parameters: eight sources, the edge, strobe, stack and inversion masks at their defaults, INTR at index 6 and NMI at index 5. With these values, every source kind is within reach of one stimulus table. These cases include:
- an edge that arrives in the same cycle as its own recognition
- a stack-writing source stalled on the write buffer
- NMI blocking across a handler return
- pending latches that drain one per boundary

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam int unsigned SRC_N = 8;
  // source indices, lowest index has highest priority
  localparam int unsigned IX_BCHK = 0;
  localparam int unsigned IX_RUNSTOP = 1;
  localparam int unsigned IX_FLUSH = 2;
  localparam int unsigned IX_SMM = 3;
  localparam int unsigned IX_INIT = 4;
  localparam int unsigned IX_NMI = 5;
  localparam int unsigned IX_INTR = 6;
  localparam int unsigned IX_STPCK = 7;
  localparam logic [SRC_N-1:0] DEF_EDGE_MASK = 8'b0011_1100;
  localparam logic [SRC_N-1:0] DEF_STROBE_MASK = 8'b0000_0001;
  localparam logic [SRC_N-1:0] DEF_STACK_MASK = 8'b0110_1001;
  localparam logic [SRC_N-1:0] DEF_INV_MASK = 8'b0000_0010;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_ACTIVE = 2'd2
  } rec_state_t;
endpackage

// File: rtl/intr_src_cond.sv
module intr_src_cond #(
  parameter int unsigned N = 8,
  parameter logic [N-1:0] EDGE_MASK = 8'b0011_1100,
  parameter logic [N-1:0] STROBE_MASK = 8'b0000_0001,
  parameter logic [N-1:0] INV_MASK = 8'b0000_0010
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin_raw,
  input  logic         bus_rdy,
  input  logic [N-1:0] clr,
  output logic [N-1:0] req
);
  logic [N-1:0] norm;
  assign norm = pin_raw ^ INV_MASK;

  for (genvar i = 0; i < N; i++) begin : g_src
    if (EDGE_MASK[i]) begin : g_edge
      logic prev_q;
      logic pend_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          prev_q <= 1'b0;
          pend_q <= 1'b0;
        end else begin
          prev_q <= norm[i];
          pend_q <= (pend_q & ~clr[i]) | (norm[i] & ~prev_q);
        end
      end
      assign req[i] = pend_q;

      AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !clr[i]) |=> pend_q); // R3
      AST_EDGE_RESET: assert property (@(posedge clk) disable iff (rst)
        (pend_q && clr[i] && !(norm[i] && !prev_q)) |=> !pend_q); // R3
    end else if (STROBE_MASK[i]) begin : g_strobe
      logic smp_q;
      always_ff @(posedge clk) begin
        if (rst) smp_q <= 1'b0;
        else if (bus_rdy) smp_q <= norm[i];
        else if (clr[i]) smp_q <= 1'b0;
      end
      assign req[i] = smp_q;

      AST_STROBE_ONLY: assert property (@(posedge clk) disable iff (rst)
        (!bus_rdy && !smp_q) |=> !smp_q); // R5
    end else begin : g_level
      assign req[i] = norm[i];
    end
  end
endmodule

// File: rtl/intr_prio_sel.sv
module intr_prio_sel #(
  parameter int unsigned N = 8,
  parameter int unsigned INTR_IX = 6,
  parameter int unsigned NMI_IX = 5
) (
  input  logic [N-1:0] req,
  input  logic         ie_flag,
  input  logic         nmi_blk,
  output logic [N-1:0] win,
  output logic         any
);
  logic [N-1:0] mask;
  logic [N-1:0] elig;

  always_comb begin
    mask = '1;
    if (!ie_flag) mask[INTR_IX] = 1'b0;
    if (nmi_blk) mask[NMI_IX] = 1'b0;
  end

  assign elig = req & mask;
  // isolate the lowest set bit: lowest index is highest priority
  assign win = elig & (~elig + {{(N-1){1'b0}}, 1'b1});
  assign any = |elig;
endmodule

// File: rtl/intr_recog.sv
module intr_recog
  import intr_pkg::*;
#(
  parameter int unsigned N = SRC_N,
  parameter logic [N-1:0] EDGE_MASK = DEF_EDGE_MASK,
  parameter logic [N-1:0] STROBE_MASK = DEF_STROBE_MASK,
  parameter logic [N-1:0] STACK_MASK = DEF_STACK_MASK,
  parameter logic [N-1:0] INV_MASK = DEF_INV_MASK,
  parameter int unsigned INTR_IX = IX_INTR,
  parameter int unsigned NMI_IX = IX_NMI
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] irq_pin,
  input  logic         bus_rdy,
  input  logic         retire_bnd,
  input  logic         ie_flag,
  input  logic         wbe,
  input  logic         nmi_iret,
  input  logic         svc_done,
  output logic [N-1:0] recog_code,
  output logic         flush_pulse,
  output logic         busy
);
  rec_state_t   state_q;
  logic [N-1:0] sel_q;
  logic [N-1:0] req;
  logic [N-1:0] win;
  logic         any;
  logic [N-1:0] fire;
  logic         nmi_act_q;

  intr_src_cond #(
    .N(N), .EDGE_MASK(EDGE_MASK), .STROBE_MASK(STROBE_MASK), .INV_MASK(INV_MASK)
  ) u_cond (
    .clk(clk), .rst(rst), .pin_raw(irq_pin), .bus_rdy(bus_rdy),
    .clr(fire), .req(req)
  );

  intr_prio_sel #(.N(N), .INTR_IX(INTR_IX), .NMI_IX(NMI_IX)) u_sel (
    .req(req), .ie_flag(ie_flag), .nmi_blk(nmi_act_q), .win(win), .any(any)
  );

  always_comb begin
    fire = '0;
    case (state_q)
      ST_IDLE:
        if (retire_bnd && any && (((win & STACK_MASK) == '0) || wbe)) fire = win;
      ST_WAIT:
        if (wbe) fire = sel_q;
      default: fire = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      sel_q       <= '0;
      recog_code  <= '0;
      flush_pulse <= 1'b0;
    end else begin
      recog_code  <= fire;
      flush_pulse <= |fire;
      case (state_q)
        ST_IDLE:
          if (retire_bnd && any) begin
            sel_q   <= win;
            state_q <= (fire != '0) ? ST_ACTIVE : ST_WAIT;
          end
        ST_WAIT:
          if (wbe) state_q <= ST_ACTIVE;
        ST_ACTIVE:
          if (svc_done) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) nmi_act_q <= 1'b0;
    else if (fire[NMI_IX]) nmi_act_q <= 1'b1;
    else if (nmi_iret) nmi_act_q <= 1'b0;
  end

  assign busy = (state_q != ST_IDLE);

  AST_CODE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(recog_code)); // R6
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (recog_code != '0) |=> (recog_code == '0)); // R2
  AST_FLUSH_PAIR: assert property (@(posedge clk) disable iff (rst)
    flush_pulse == (recog_code != '0)); // R2
  AST_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    ((recog_code != '0) && $past(state_q) == ST_IDLE) |-> $past(retire_bnd)); // R2
  AST_INTR_MASKED: assert property (@(posedge clk) disable iff (rst)
    (recog_code[INTR_IX] && $past(state_q) == ST_IDLE) |-> $past(ie_flag)); // R7
  AST_NMI_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    recog_code[NMI_IX] |-> !$past(nmi_act_q)); // R8
  AST_STACK_WBE: assert property (@(posedge clk) disable iff (rst)
    ((recog_code & STACK_MASK) != '0) |-> $past(wbe)); // R9
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (busy && !svc_done) |=> busy); // R10
endmodule

// File: tb/intr_recog_tb.sv
module intr_recog_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] irq_pin = 8'h02;
  logic       bus_rdy = 1'b0, retire_bnd = 1'b0, ie_flag = 1'b0, wbe = 1'b0;
  logic       nmi_iret = 1'b0, svc_done = 1'b0;
  logic [7:0] recog_code;
  logic       flush_pulse, busy;
  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  intr_recog u_dut (
    .clk(clk), .rst(rst), .irq_pin(irq_pin), .bus_rdy(bus_rdy),
    .retire_bnd(retire_bnd), .ie_flag(ie_flag), .wbe(wbe),
    .nmi_iret(nmi_iret), .svc_done(svc_done), .recog_code(recog_code),
    .flush_pulse(flush_pulse), .busy(busy)
  );

  // entry: {active-high pins, ie_flag, wbe, expected code}
  localparam logic [17:0] VEC [8] = '{
    {8'b0100_0000, 1'b1, 1'b1, 8'b0100_0000},
    {8'b0100_0000, 1'b0, 1'b1, 8'b0000_0000},
    {8'b1111_1111, 1'b1, 1'b1, 8'b0000_0001},
    {8'b1111_1110, 1'b1, 1'b1, 8'b0000_0010},
    {8'b1110_0000, 1'b1, 1'b1, 8'b0010_0000},
    {8'b1100_0000, 1'b0, 1'b1, 8'b1000_0000},
    {8'b0001_0000, 1'b1, 1'b0, 8'b0001_0000},
    {8'b0000_1000, 1'b1, 1'b0, 8'b0000_0000}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_norm(input logic [7:0] v);
    irq_pin = v ^ 8'h02;
  endtask

  task automatic chk(input logic ok, input string req, input logic [7:0] act,
                     input logic [7:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; set_norm(8'h00); bus_rdy = 0; retire_bnd = 0;
    ie_flag = 0; wbe = 0; nmi_iret = 0; svc_done = 0;
    tick(); tick();
    rst = 1'b0;
  endtask

  task automatic boundary();
    retire_bnd = 1'b1; tick(); retire_bnd = 1'b0;
  endtask

  task automatic finish_svc();
    svc_done = 1'b1; tick(); svc_done = 1'b0;
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    chk(recog_code == 8'h00 && !flush_pulse && !busy, "R1 reset", recog_code, 8'h00);

    // table walk: R4 R6 R7 R9
    for (int k = 0; k < 8; k++) begin
      do_reset();
      set_norm(VEC[k][17:10]); ie_flag = VEC[k][9]; wbe = VEC[k][8];
      bus_rdy = 1'b1; tick(); bus_rdy = 1'b0; tick();
      boundary();
      chk(recog_code == VEC[k][7:0] && flush_pulse == (VEC[k][7:0] != 0),
          "R6 table", recog_code, VEC[k][7:0]);
    end

    // R2: no boundary, no recognition
    do_reset(); ie_flag = 1; wbe = 1; set_norm(8'h40); tick(); tick();
    chk(recog_code == 8'h00 && !busy, "R2 no boundary", recog_code, 8'h00);
    boundary();
    chk(recog_code == 8'h40 && flush_pulse, "R2 boundary", recog_code, 8'h40);
    tick();
    chk(recog_code == 8'h00 && !flush_pulse, "R2 one cycle", recog_code, 8'h00);

    // R4: held source dropped before boundary
    do_reset(); ie_flag = 1; wbe = 1; set_norm(8'h40); tick(); set_norm(8'h00); tick();
    boundary();
    chk(recog_code == 8'h00, "R4 level dropped", recog_code, 8'h00);

    // R3: edge persists after pin drops
    do_reset(); wbe = 1; set_norm(8'h04); tick(); set_norm(8'h00); tick(); tick();
    boundary();
    chk(recog_code == 8'h04, "R3 edge latched", recog_code, 8'h04);

    // R3: new edge in the recognition cycle re-sets the latch
    do_reset(); wbe = 1; set_norm(8'h04); tick(); set_norm(8'h00); tick();
    set_norm(8'h04); boundary();
    chk(recog_code == 8'h04, "R3 first", recog_code, 8'h04);
    finish_svc(); boundary();
    chk(recog_code == 8'h04, "R3 re-edge kept", recog_code, 8'h04);

    // R5: bus-check needs strobe
    do_reset(); wbe = 1; set_norm(8'h01); tick(); tick(); boundary();
    chk(recog_code == 8'h00, "R5 no strobe", recog_code, 8'h00);
    bus_rdy = 1; tick(); bus_rdy = 0; set_norm(8'h00); tick(); boundary();
    chk(recog_code == 8'h01, "R5 strobed", recog_code, 8'h01);

    // R9: stack source waits for wbe
    do_reset(); set_norm(8'h08); tick(); set_norm(8'h00); boundary();
    chk(recog_code == 8'h00 && busy, "R9 stalled", recog_code, 8'h00);
    tick();
    chk(recog_code == 8'h00 && busy, "R9 still stalled", recog_code, 8'h00);
    wbe = 1; tick();
    chk(recog_code == 8'h08 && flush_pulse, "R9 released", recog_code, 8'h08);

    // R8: NMI blocked until return
    do_reset(); wbe = 1; set_norm(8'h20); tick(); set_norm(8'h00); boundary();
    chk(recog_code == 8'h20, "R8 first nmi", recog_code, 8'h20);
    finish_svc(); set_norm(8'h20); tick(); set_norm(8'h00); tick(); boundary();
    chk(recog_code == 8'h00 && !busy, "R8 blocked", recog_code, 8'h00);
    nmi_iret = 1; tick(); nmi_iret = 0; boundary();
    chk(recog_code == 8'h20, "R8 after iret", recog_code, 8'h20);

    // R10: busy blocks boundaries, remaining latch drains later
    do_reset(); wbe = 1; set_norm(8'h0C); tick(); set_norm(8'h00); boundary();
    chk(recog_code == 8'h04 && busy, "R10 first", recog_code, 8'h04);
    boundary();
    chk(recog_code == 8'h00 && busy, "R10 busy ignores", recog_code, 8'h00);
    finish_svc();
    chk(!busy, "R10 done", {7'd0, busy}, 8'h00);
    boundary();
    chk(recog_code == 8'h08, "R10 drained", recog_code, 8'h08);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule